// File: doc/BRIEF.md
# Branch prediction history queue

This block keeps the ordered list of branch predictions that are still in flight in a pipelined front end. Each prediction is stored as a record tagged with a monotonically increasing sequence number. A record holds the branch PC, the predicted direction, a thread id, the return-stack state saved at prediction time, and flags for return, call, indirect, "return stack was used" and "return stack was pushed". Records enter at the young end. Two kinds of walk remove them. A commit walk retires records from the old end and sends a normal direction update for each. A squash walk removes records from the young end and sends a return-stack repair for each record that needs one.

A mispredict resolution runs a squash walk, and the record of the branch that was resolved survives it. That record is then fixed. Its direction is replaced by the real outcome and a squash-type direction update is sent. A taken, non-indirect branch also gets its corrected target written to the target buffer. A branch that was not taken undoes its own return-stack effect. Every walk handles one record per clock cycle, so at most one repair command leaves the block in any cycle. All commands are accepted only while the block is idle. Sequence numbers are compared as plain unsigned values.

Top module: `bhist_queue`

## Requirements
- R1: After reset the queue is empty, `busy` is low, `insReady` is high, and `updValid`, `btbWrValid` and `orderErr` are low with `rasOp` = 0.
- R2: An insert is accepted when `insValid` and `insReady` are both high. `insReady` is low while the queue holds DEPTH records, while `busy` is high, and while any of `cmtValid`, `sqValid` or `misValid` is high.
- R3: A commit walk retires the oldest record each cycle while its sequence number is less than or equal to `cmtSeq`. For each retired record it emits one `updValid` pulse with `updSquash`=0 and that record's PC, predicted direction and thread id. The walk stops at the first record with a larger sequence number, or when the queue is empty.
- R4: A squash walk removes the youngest record each cycle while its sequence number is greater than the squash sequence number. Records with a sequence number less than or equal to it stay queued.
- R5: A removed record with stack-used set yields `rasOp`=1 (restore), with `rasIdx` and `rasTgt` set to the index and target saved in that record.
- R6: A removed record with stack-used clear and both call and pushed set yields `rasOp`=2 (pop). Any other removed record yields `rasOp`=0. The value 3 never appears.
- R7: On a mispredict, once the squash walk ends, the youngest remaining record must carry exactly `misSeq`. If it does not, `orderErr` pulses for one cycle, no update or write is sent, and the record is left unchanged.
- R8: A mispredict fix overwrites the record's direction with `misTaken` and emits `updValid` with `updSquash`=1, the record's PC and `updTaken`=`misTaken`. A later commit of that record reports the corrected direction.
- R9: When `misTaken` is 1 and the record is not indirect, the fix pulses `btbWrValid` with the record's PC and `misTarget`. An indirect record gets no target write.
- R10: When `misTaken` is 1 for a return whose stack-used flag was clear, the fix sets stack-used, so a later squash of that record issues a restore.
- R11: When `misTaken` is 0 and stack-used is set, the fix issues a restore with the saved index and target, and clears stack-used.
- R12: When `misTaken` is 0, stack-used is clear, and call and pushed are both set, the fix issues a pop and clears pushed.
- R13: A mispredict that finds the queue empty sends no update, no repair, no target write and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| insValid | input | 1 | Insert a new prediction record |
| insReady | output | 1 | Insert can be accepted this cycle |
| insSeq | input | SEQ_W | Sequence number of the new record |
| insPc | input | PC_W | Branch PC |
| insTaken | input | 1 | Predicted direction |
| insTid | input | TID_W | Thread id |
| insRet | input | 1 | Record is a return |
| insCall | input | 1 | Record is a call |
| insInd | input | 1 | Record is an indirect branch |
| insUsedStk | input | 1 | Prediction took its target from the return stack |
| insPushed | input | 1 | Prediction pushed onto the return stack |
| insStkIdx | input | IDX_W | Saved return-stack top index |
| insStkTgt | input | PC_W | Saved return-stack top target |
| cmtValid | input | 1 | Start a commit walk |
| cmtSeq | input | SEQ_W | Commit bound (inclusive) |
| sqValid | input | 1 | Start a plain squash walk |
| sqSeq | input | SEQ_W | Squash bound (records above it are removed) |
| misValid | input | 1 | Start a mispredict resolution |
| misSeq | input | SEQ_W | Sequence number of the resolved branch |
| misTaken | input | 1 | Actual direction |
| misTarget | input | PC_W | Corrected target |
| busy | output | 1 | A walk or fix is in progress |
| updValid | output | 1 | Direction update pulse |
| updSquash | output | 1 | Update comes from a mispredict fix |
| updPc | output | PC_W | PC for the update |
| updTaken | output | 1 | Direction for the update |
| updTid | output | TID_W | Thread id for the update |
| rasOp | output | 2 | Repair command: 0 none, 1 restore, 2 pop |
| rasIdx | output | IDX_W | Index for restore |
| rasTgt | output | PC_W | Target for restore |
| btbWrValid | output | 1 | Corrected-target write pulse |
| btbWrPc | output | PC_W | PC to write |
| btbWrTgt | output | PC_W | Target to write |
| orderErr | output | 1 | Resolved record did not match `misSeq` |

## Verification
A command is sampled at clock edge E0, and every later edge makes one walk step. All results are registered, so the k-th retired or removed record shows its update or repair in the cycle after edge Ek. `busy` falls after the edge following the last removal. A mispredict result appears one edge after the walk ends: after E2 when nothing younger is queued, and after E(k+2) when k younger records are removed. The bench logs every output for six cycles after each command and compares each log slot against the slot the timing above predicts, so an early, late, missing or repeated pulse fails a check.

// File: rtl/bhist_pkg.sv
package bhist_pkg;

  typedef enum logic [1:0] {
    RAS_NONE    = 2'd0,
    RAS_RESTORE = 2'd1,
    RAS_POP     = 2'd2
  } ras_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMT,
    ST_SQW,
    ST_FIX
  } walk_state_e;

  // strobes from control to datapath, one action per cycle
  typedef struct packed {
    logic push;
    logic capture;
    logic retire;
    logic dropYoung;
    logic fix;
    logic flagErr;
  } bhq_strobe_t;

endpackage

// File: rtl/bhist_ctrl.sv
module bhist_ctrl
  import bhist_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        insValid,
  input  logic        cmtValid,
  input  logic        sqValid,
  input  logic        misValid,
  input  logic        isEmpty,
  input  logic        isFull,
  input  logic        oldLe,
  input  logic        youngGt,
  input  logic        youngEq,
  output bhq_strobe_t stb,
  output logic        busy,
  output logic        insReady
);

  walk_state_e state, stateNxt;
  logic        isMis;

  assign busy     = (state != ST_IDLE);
  assign insReady = (state == ST_IDLE) && !isFull && !cmtValid && !sqValid && !misValid;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (misValid || sqValid) begin
          stb.capture = 1'b1;
          stateNxt    = ST_SQW;
        end else if (cmtValid) begin
          stb.capture = 1'b1;
          stateNxt    = ST_CMT;
        end else begin
          stb.push = insValid && insReady;
        end
      end
      ST_CMT: begin
        if (!isEmpty && oldLe) stb.retire = 1'b1;
        else                   stateNxt   = ST_IDLE;
      end
      ST_SQW: begin
        if (!isEmpty && youngGt) stb.dropYoung = 1'b1;
        else                     stateNxt      = isMis ? ST_FIX : ST_IDLE;
      end
      ST_FIX: begin
        if (!isEmpty) begin
          stb.fix     = youngEq;
          stb.flagErr = !youngEq;
        end
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      isMis <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE && (misValid || sqValid)) isMis <= misValid;
    end
  end

endmodule

// File: rtl/bhist_dpath.sv
module bhist_dpath
  import bhist_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  parameter int PC_W  = 16,
  parameter int IDX_W = 4,
  parameter int TID_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  bhq_strobe_t       stb,
  input  logic [SEQ_W-1:0]  opSeq,
  input  logic              misTaken,
  input  logic [PC_W-1:0]   misTarget,
  input  logic [SEQ_W-1:0]  insSeq,
  input  logic [PC_W-1:0]   insPc,
  input  logic              insTaken,
  input  logic [TID_W-1:0]  insTid,
  input  logic              insRet,
  input  logic              insCall,
  input  logic              insInd,
  input  logic              insUsedStk,
  input  logic              insPushed,
  input  logic [IDX_W-1:0]  insStkIdx,
  input  logic [PC_W-1:0]   insStkTgt,
  output logic              isEmpty,
  output logic              isFull,
  output logic              oldLe,
  output logic              youngGt,
  output logic              youngEq,
  output logic              updValid,
  output logic              updSquash,
  output logic [PC_W-1:0]   updPc,
  output logic              updTaken,
  output logic [TID_W-1:0]  updTid,
  output ras_op_e           rasOp,
  output logic [IDX_W-1:0]  rasIdx,
  output logic [PC_W-1:0]   rasTgt,
  output logic              btbWrValid,
  output logic [PC_W-1:0]   btbWrPc,
  output logic [PC_W-1:0]   btbWrTgt,
  output logic              orderErr
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [SEQ_W-1:0] seqMem  [DEPTH];
  logic [PC_W-1:0]  pcMem   [DEPTH];
  logic [TID_W-1:0] tidMem  [DEPTH];
  logic [IDX_W-1:0] idxMem  [DEPTH];
  logic [PC_W-1:0]  tgtMem  [DEPTH];
  logic             takenMem[DEPTH];
  logic             retMem  [DEPTH];
  logic             callMem [DEPTH];
  logic             indMem  [DEPTH];
  logic             usedMem [DEPTH];
  logic             pushMem [DEPTH];

  logic [PTR_W-1:0] headPtr, tailPtr, yPtr;
  logic [CNT_W-1:0] count;
  logic [SEQ_W-1:0] cmdSeq;
  logic             actTaken;
  logic [PC_W-1:0]  corrTgt;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptrDec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - PTR_W'(1);
  endfunction

  assign yPtr    = ptrDec(tailPtr);
  assign isEmpty = (count == '0);
  assign isFull  = (count == CNT_W'(DEPTH));
  assign oldLe   = (seqMem[headPtr] <= cmdSeq);
  assign youngGt = (seqMem[yPtr] > cmdSeq);
  assign youngEq = (seqMem[yPtr] == cmdSeq);

  // record storage, no reset needed: occupancy is tracked by count
  always_ff @(posedge clk) begin
    if (stb.push) begin
      seqMem[tailPtr]   <= insSeq;
      pcMem[tailPtr]    <= insPc;
      tidMem[tailPtr]   <= insTid;
      idxMem[tailPtr]   <= insStkIdx;
      tgtMem[tailPtr]   <= insStkTgt;
      takenMem[tailPtr] <= insTaken;
      retMem[tailPtr]   <= insRet;
      callMem[tailPtr]  <= insCall;
      indMem[tailPtr]   <= insInd;
      usedMem[tailPtr]  <= insUsedStk;
      pushMem[tailPtr]  <= insPushed;
    end
    if (stb.fix) begin
      takenMem[yPtr] <= actTaken;
      if (actTaken) begin
        if (retMem[yPtr] && !usedMem[yPtr]) usedMem[yPtr] <= 1'b1;
      end else if (usedMem[yPtr]) begin
        usedMem[yPtr] <= 1'b0;
      end else if (callMem[yPtr] && pushMem[yPtr]) begin
        pushMem[yPtr] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr  <= '0;
      tailPtr  <= '0;
      count    <= '0;
      cmdSeq   <= '0;
      actTaken <= 1'b0;
      corrTgt  <= '0;
    end else begin
      if (stb.capture) begin
        cmdSeq   <= opSeq;
        actTaken <= misTaken;
        corrTgt  <= misTarget;
      end
      if (stb.push) begin
        tailPtr <= ptrInc(tailPtr);
        count   <= count + CNT_W'(1);
      end else if (stb.retire) begin
        headPtr <= ptrInc(headPtr);
        count   <= count - CNT_W'(1);
      end else if (stb.dropYoung) begin
        tailPtr <= yPtr;
        count   <= count - CNT_W'(1);
      end
    end
  end

  // registered result pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      updValid   <= 1'b0;
      updSquash  <= 1'b0;
      updPc      <= '0;
      updTaken   <= 1'b0;
      updTid     <= '0;
      rasOp      <= RAS_NONE;
      rasIdx     <= '0;
      rasTgt     <= '0;
      btbWrValid <= 1'b0;
      btbWrPc    <= '0;
      btbWrTgt   <= '0;
      orderErr   <= 1'b0;
    end else begin
      updValid   <= 1'b0;
      btbWrValid <= 1'b0;
      rasOp      <= RAS_NONE;
      orderErr   <= stb.flagErr;
      if (stb.retire) begin
        updValid  <= 1'b1;
        updSquash <= 1'b0;
        updPc     <= pcMem[headPtr];
        updTaken  <= takenMem[headPtr];
        updTid    <= tidMem[headPtr];
      end
      if (stb.dropYoung) begin
        rasIdx <= idxMem[yPtr];
        rasTgt <= tgtMem[yPtr];
        if (usedMem[yPtr])                       rasOp <= RAS_RESTORE;
        else if (callMem[yPtr] && pushMem[yPtr]) rasOp <= RAS_POP;
      end
      if (stb.fix) begin
        updValid  <= 1'b1;
        updSquash <= 1'b1;
        updPc     <= pcMem[yPtr];
        updTaken  <= actTaken;
        updTid    <= tidMem[yPtr];
        rasIdx    <= idxMem[yPtr];
        rasTgt    <= tgtMem[yPtr];
        if (actTaken) begin
          if (!indMem[yPtr]) begin
            btbWrValid <= 1'b1;
            btbWrPc    <= pcMem[yPtr];
            btbWrTgt   <= corrTgt;
          end
        end else if (usedMem[yPtr]) begin
          rasOp <= RAS_RESTORE;
        end else if (callMem[yPtr] && pushMem[yPtr]) begin
          rasOp <= RAS_POP;
        end
      end
    end
  end

endmodule

// File: rtl/bhist_queue.sv
module bhist_queue
  import bhist_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  parameter int PC_W  = 16,
  parameter int IDX_W = 4,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  output logic             insReady,
  input  logic [SEQ_W-1:0] insSeq,
  input  logic [PC_W-1:0]  insPc,
  input  logic             insTaken,
  input  logic [TID_W-1:0] insTid,
  input  logic             insRet,
  input  logic             insCall,
  input  logic             insInd,
  input  logic             insUsedStk,
  input  logic             insPushed,
  input  logic [IDX_W-1:0] insStkIdx,
  input  logic [PC_W-1:0]  insStkTgt,
  input  logic             cmtValid,
  input  logic [SEQ_W-1:0] cmtSeq,
  input  logic             sqValid,
  input  logic [SEQ_W-1:0] sqSeq,
  input  logic             misValid,
  input  logic [SEQ_W-1:0] misSeq,
  input  logic             misTaken,
  input  logic [PC_W-1:0]  misTarget,
  output logic             busy,
  output logic             updValid,
  output logic             updSquash,
  output logic [PC_W-1:0]  updPc,
  output logic             updTaken,
  output logic [TID_W-1:0] updTid,
  output logic [1:0]       rasOp,
  output logic [IDX_W-1:0] rasIdx,
  output logic [PC_W-1:0]  rasTgt,
  output logic             btbWrValid,
  output logic [PC_W-1:0]  btbWrPc,
  output logic [PC_W-1:0]  btbWrTgt,
  output logic             orderErr
);

  bhq_strobe_t      stb;
  logic             isEmpty, isFull, oldLe, youngGt, youngEq;
  logic [SEQ_W-1:0] opSeq;
  ras_op_e          rasOpE;

  assign opSeq = misValid ? misSeq : (sqValid ? sqSeq : cmtSeq);
  assign rasOp = rasOpE;

  bhist_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .insValid(insValid), .cmtValid(cmtValid), .sqValid(sqValid), .misValid(misValid),
    .isEmpty(isEmpty), .isFull(isFull), .oldLe(oldLe), .youngGt(youngGt), .youngEq(youngEq),
    .stb(stb), .busy(busy), .insReady(insReady)
  );

  bhist_dpath #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .PC_W(PC_W), .IDX_W(IDX_W), .TID_W(TID_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .opSeq(opSeq), .misTaken(misTaken), .misTarget(misTarget),
    .insSeq(insSeq), .insPc(insPc), .insTaken(insTaken), .insTid(insTid),
    .insRet(insRet), .insCall(insCall), .insInd(insInd),
    .insUsedStk(insUsedStk), .insPushed(insPushed),
    .insStkIdx(insStkIdx), .insStkTgt(insStkTgt),
    .isEmpty(isEmpty), .isFull(isFull), .oldLe(oldLe), .youngGt(youngGt), .youngEq(youngEq),
    .updValid(updValid), .updSquash(updSquash), .updPc(updPc), .updTaken(updTaken),
    .updTid(updTid), .rasOp(rasOpE), .rasIdx(rasIdx), .rasTgt(rasTgt),
    .btbWrValid(btbWrValid), .btbWrPc(btbWrPc), .btbWrTgt(btbWrTgt),
    .orderErr(orderErr)
  );

endmodule

// File: rtl/bhist_queue_chk.sv
module bhist_queue_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       insReady,
  input logic       isFull,
  input logic       updValid,
  input logic       updSquash,
  input logic       btbWrValid,
  input logic [1:0] rasOp,
  input logic       orderErr
);

  // R6
  ras_op_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    rasOp != 2'd3);

  // R5
  ras_after_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rasOp != 2'd0) |-> $past(busy));

  // R3
  upd_after_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    updValid |-> $past(busy));

  // R9
  btb_with_fix_chk: assert property (@(posedge clk) disable iff (!rstN)
    btbWrValid |-> (updValid && updSquash));

  // R7
  err_no_upd_chk: assert property (@(posedge clk) disable iff (!rstN)
    orderErr |-> (!updValid && !btbWrValid && rasOp == 2'd0));

  // R2
  full_blocks_ins_chk: assert property (@(posedge clk) disable iff (!rstN)
    isFull |-> !insReady);

endmodule

bind bhist_queue bhist_queue_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .insReady(insReady), .isFull(isFull),
  .updValid(updValid), .updSquash(updSquash), .btbWrValid(btbWrValid),
  .rasOp(rasOp), .orderErr(orderErr)
);

// File: tb/test_bhist_queue.sv
`timescale 1ns/1ps
module test_bhist_queue;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int SEQ_W = 8;
  localparam int PC_W  = 16;
  localparam int IDX_W = 4;
  localparam int TID_W = 2;
  localparam int NLOG  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic insValid = 0, insTaken = 0, insRet = 0, insCall = 0, insInd = 0, insUsedStk = 0, insPushed = 0;
  logic [SEQ_W-1:0] insSeq = '0, cmtSeq = '0, sqSeq = '0, misSeq = '0;
  logic [PC_W-1:0]  insPc = '0, insStkTgt = '0, misTarget = '0;
  logic [TID_W-1:0] insTid = '0;
  logic [IDX_W-1:0] insStkIdx = '0;
  logic cmtValid = 0, sqValid = 0, misValid = 0, misTaken = 0;
  logic insReady, busy, updValid, updSquash, updTaken, btbWrValid, orderErr;
  logic [PC_W-1:0]  updPc, rasTgt, btbWrPc, btbWrTgt;
  logic [TID_W-1:0] updTid;
  logic [1:0]       rasOp;
  logic [IDX_W-1:0] rasIdx;

  int nChk = 0, nFail = 0;
  bit done = 0;

  // per-cycle logs after a command, slot t = after walk edge Et
  logic            lBusy[1:NLOG], lRdy[1:NLOG], lUpd[1:NLOG], lSq[1:NLOG], lTk[1:NLOG];
  logic            lBtb[1:NLOG], lErr[1:NLOG];
  logic [PC_W-1:0] lPc[1:NLOG], lRasTgt[1:NLOG], lBtbPc[1:NLOG], lBtbTgt[1:NLOG];
  logic [1:0]      lRas[1:NLOG];
  logic [IDX_W-1:0] lRasIdx[1:NLOG];
  logic [TID_W-1:0] lTid[1:NLOG];

  bhist_queue #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .PC_W(PC_W), .IDX_W(IDX_W), .TID_W(TID_W)) i_bhist_queue (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insReady(insReady), .insSeq(insSeq),
    .insPc(insPc), .insTaken(insTaken), .insTid(insTid), .insRet(insRet), .insCall(insCall),
    .insInd(insInd), .insUsedStk(insUsedStk), .insPushed(insPushed), .insStkIdx(insStkIdx),
    .insStkTgt(insStkTgt), .cmtValid(cmtValid), .cmtSeq(cmtSeq), .sqValid(sqValid),
    .sqSeq(sqSeq), .misValid(misValid), .misSeq(misSeq), .misTaken(misTaken),
    .misTarget(misTarget), .busy(busy), .updValid(updValid), .updSquash(updSquash),
    .updPc(updPc), .updTaken(updTaken), .updTid(updTid), .rasOp(rasOp), .rasIdx(rasIdx),
    .rasTgt(rasTgt), .btbWrValid(btbWrValid), .btbWrPc(btbWrPc), .btbWrTgt(btbWrTgt),
    .orderErr(orderErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic walkLog();
    for (int t = 1; t <= NLOG; t++) begin
      tick();
      lBusy[t] = busy; lRdy[t] = insReady; lUpd[t] = updValid; lSq[t] = updSquash;
      lTk[t] = updTaken; lPc[t] = updPc; lTid[t] = updTid; lRas[t] = rasOp;
      lRasIdx[t] = rasIdx; lRasTgt[t] = rasTgt; lBtb[t] = btbWrValid;
      lBtbPc[t] = btbWrPc; lBtbTgt[t] = btbWrTgt; lErr[t] = orderErr;
    end
  endtask

  task automatic ins(input logic [SEQ_W-1:0] s, input logic [PC_W-1:0] pc, input logic tk,
                     input logic rt, input logic cl, input logic ind, input logic used,
                     input logic psh, input logic [IDX_W-1:0] idx, input logic [PC_W-1:0] tgt,
                     input logic [TID_W-1:0] tid);
    insValid = 1; insSeq = s; insPc = pc; insTaken = tk; insRet = rt; insCall = cl;
    insInd = ind; insUsedStk = used; insPushed = psh; insStkIdx = idx; insStkTgt = tgt; insTid = tid;
    #1 check("R2 insReady before insert", insReady, 1'b1);
    @(posedge clk); #1;
    insValid = 0;
  endtask

  task automatic doCommit(input logic [SEQ_W-1:0] s);
    cmtValid = 1; cmtSeq = s; tick(); cmtValid = 0; walkLog();
  endtask

  task automatic doSquash(input logic [SEQ_W-1:0] s);
    sqValid = 1; sqSeq = s; tick(); sqValid = 0; walkLog();
  endtask

  task automatic doMis(input logic [SEQ_W-1:0] s, input logic tk, input logic [PC_W-1:0] tgt);
    misValid = 1; misSeq = s; misTaken = tk; misTarget = tgt; tick(); misValid = 0; walkLog();
  endtask

  task automatic testReset();
    check("R1 busy", busy, 0);
    check("R1 insReady", insReady, 1);
    check("R1 updValid", updValid, 0);
    check("R1 rasOp", rasOp, 0);
    check("R1 btbWrValid", btbWrValid, 0);
    check("R1 orderErr", orderErr, 0);
  endtask

  task automatic testFillCommit();
    ins(10, 16'h1000, 1, 0, 0, 0, 0, 0, 0, 0, 2);
    ins(11, 16'h1004, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    ins(12, 16'h1008, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    ins(13, 16'h100c, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R2 full insReady", insReady, 0);
    doCommit(11);
    check("R3 upd1 valid", lUpd[1], 1);
    check("R3 upd1 pc", lPc[1], 16'h1000);
    check("R3 upd1 taken", lTk[1], 1);
    check("R3 upd1 tid", lTid[1], 2);
    check("R3 upd1 squash", lSq[1], 0);
    check("R3 upd2 pc", lPc[2], 16'h1004);
    check("R3 upd2 taken", lTk[2], 0);
    check("R3 stop no upd", lUpd[3], 0);
    check("R3 busy drops", lBusy[3], 0);
    check("R2 insReady low when busy", lRdy[1], 0);
    doCommit(20);
    check("R3 drain upd1 pc", lPc[1], 16'h1008);
    check("R3 drain upd2 pc", lPc[2], 16'h100c);
    check("R3 drain empty stop", lUpd[3], 0);
  endtask

  task automatic testSquash();
    ins(20, 16'h2000, 0, 1, 0, 0, 1, 0, 3, 16'h00a0, 0);
    ins(21, 16'h2004, 1, 0, 1, 0, 0, 1, 4, 16'h00a4, 0);
    ins(22, 16'h2008, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    ins(23, 16'h200c, 0, 1, 0, 0, 1, 0, 5, 16'h00b0, 0);
    doSquash(20);
    check("R5 restore op", lRas[1], 1);
    check("R5 restore idx", lRasIdx[1], 5);
    check("R5 restore tgt", lRasTgt[1], 16'h00b0);
    check("R6 plain none", lRas[2], 0);
    check("R6 pop op", lRas[3], 2);
    check("R4 walk stops", lRas[4], 0);
    check("R4 busy", {lBusy[3], lBusy[4]}, 2'b10);
    doCommit(30);
    check("R4 survivor pc", lPc[1], 16'h2000);
    check("R4 one survivor", lUpd[2], 0);
  endtask

  task automatic testFixTaken();
    ins(40, 16'h4000, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    ins(41, 16'h4004, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    doMis(40, 1, 16'h4444);
    check("R8 no early upd", lUpd[2], 0);
    check("R8 upd valid", lUpd[3], 1);
    check("R8 upd squash", lSq[3], 1);
    check("R8 upd taken", lTk[3], 1);
    check("R8 upd pc", lPc[3], 16'h4000);
    check("R9 btb valid", lBtb[3], 1);
    check("R9 btb pc", lBtbPc[3], 16'h4000);
    check("R9 btb tgt", lBtbTgt[3], 16'h4444);
    check("R8 busy", {lBusy[2], lBusy[3]}, 2'b10);
    doCommit(45);
    check("R8 corrected dir at commit", lTk[1], 1);
    check("R8 commit squash flag", lSq[1], 0);
  endtask

  task automatic testIndirect();
    ins(50, 16'h5000, 0, 0, 0, 1, 0, 0, 0, 0, 0);
    doMis(50, 1, 16'h5555);
    check("R9 ind upd", lUpd[2], 1);
    check("R9 ind no btb", lBtb[2], 0);
    doCommit(50);
  endtask

  task automatic testRetTaken();
    ins(60, 16'h6000, 0, 1, 0, 0, 0, 0, 2, 16'h00c0, 0);
    doMis(60, 1, 16'h6666);
    check("R10 upd", lUpd[2], 1);
    check("R10 no ras at fix", lRas[2], 0);
    doSquash(59);
    check("R10 restore after set", lRas[1], 1);
    check("R10 restore idx", lRasIdx[1], 2);
    check("R10 restore tgt", lRasTgt[1], 16'h00c0);
  endtask

  task automatic testNotTakenUsed();
    ins(70, 16'h7000, 1, 1, 0, 0, 1, 0, 6, 16'h00d0, 0);
    doMis(70, 0, 16'h0);
    check("R11 restore op", lRas[2], 1);
    check("R11 restore idx", lRasIdx[2], 6);
    check("R11 restore tgt", lRasTgt[2], 16'h00d0);
    check("R11 upd taken", lTk[2], 0);
    check("R11 no btb", lBtb[2], 0);
    doSquash(69);
    check("R11 used cleared", lRas[1], 0);
  endtask

  task automatic testNotTakenCall();
    ins(80, 16'h8000, 1, 0, 1, 0, 0, 1, 7, 16'h00e0, 0);
    doMis(80, 0, 16'h0);
    check("R12 pop op", lRas[2], 2);
    doSquash(79);
    check("R12 pushed cleared", lRas[1], 0);
  endtask

  task automatic testOrderErr();
    ins(90, 16'h9000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    ins(92, 16'h9008, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    doMis(91, 1, 16'h9999);
    check("R7 err pulse", lErr[3], 1);
    check("R7 err one cycle", lErr[4], 0);
    check("R7 no upd", lUpd[3], 0);
    check("R7 no btb", lBtb[3], 0);
    doCommit(100);
    check("R7 record unchanged pc", lPc[1], 16'h9000);
    check("R7 record unchanged dir", lTk[1], 0);
  endtask

  task automatic testEmptyMis();
    doMis(5, 1, 16'h1234);
    check("R13 no upd", lUpd[2], 0);
    check("R13 no err", lErr[2], 0);
    check("R13 no btb", lBtb[2], 0);
    check("R13 no ras", lRas[2], 0);
    check("R13 busy drops", lBusy[2], 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 testReset();
    rstN = 1;
    tick();
    testReset();
    testFillCommit();
    testSquash();
    testFixTaken();
    testIndirect();
    testRetTaken();
    testNotTakenUsed();
    testNotTakenCall();
    testOrderErr();
    testEmptyMis();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule